// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Datapath

This block is the datapath half of a small 32-bit processor that runs each instruction over several clock cycles. It supports word loads and stores, register-to-register add, subtract, AND, OR and signed set-less-than, an equality branch and an absolute jump. It reuses hardware across cycles. A single memory port serves both instruction fetch and data access. A single ALU performs the PC increment, the branch-target sum, address generation and all arithmetic.

Holding registers keep values between steps: program counter, instruction, memory data, two operand latches and the ALU result. A separate sequencer drives every select line and write enable on each cycle. That sequencer sees the current instruction, the ALU zero flag and the overflow flag. The memory sits outside the block. It is read combinationally and written on the clock edge by the sequencer.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the program counter and the instruction register to 0.
- R2: `mem_addr` carries the program counter when `addr_sel`=0 and the registered ALU result when `addr_sel`=1.
- R3: ALU operand X is the PC when `opa_sel`=0 and the first operand latch when 1. For operand Y, `opb_sel` selects: 0 the second operand latch, 1 the constant 4, 2 the sign-extended `instr[15:0]`, 3 that value shifted left by two.
- R4: `alu_fn` selects the ALU operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed less-than, which yields 1 or 0.
- R5: `ovf` is high only for a signed overflow of an add (code 0) or a subtract (code 1).
- R6: The instruction register loads `mem_rdata` only on an edge where `ir_wr`=1. Otherwise `instr` holds its value.
- R7: The register written on an edge where `reg_wr`=1 is chosen by `dst_sel`: `instr[15:11]` when 1, `instr[20:16]` when 0. `wb_sel` chooses the data: the registered ALU result when 0, the memory data register when 1.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: The PC updates when `pc_wr`=1, or when `pc_wr_cond`=1 and the live ALU zero flag is set. Otherwise it holds.
- R10: `pc_src` selects the next PC: 0 the live ALU result, 1 the registered ALU result, 2 the jump target {PC[31:28], `instr[25:0]`, 2'b00}.
- R11: The operand latches, the ALU result register and the memory data register capture on every edge. The operand latches read the registers named by `instr[25:21]` and `instr[20:16]`. `mem_wdata` is the second operand latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 1 | Memory address select (0 PC, 1 ALU result register) |
| ir_wr | input | 1 | Instruction register load enable |
| reg_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field select |
| wb_sel | input | 1 | Write-back data select |
| opa_sel | input | 1 | ALU operand X select |
| opb_sel | input | 2 | ALU operand Y select |
| alu_fn | input | 3 | ALU operation code |
| pc_src | input | 2 | Next-PC source select |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by ALU zero |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (second operand latch) |
| instr | output | 32 | Current instruction register |
| zero | output | 1 | Live ALU result equals zero |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block with its defaults: a 32-bit data path and 32 registers. With those values every field position is reachable, including the full 5-bit register index and PC[31:28] in the jump target. Signed-boundary operands are also reachable: 0x7FFFFFFF, 0x80000000 and all-ones. They exercise both overflow directions and a less-than comparison whose raw difference overflows. The bench acts as the sequencer. It runs loads, register operations, a store, a taken and an untaken branch and a jump, and observes register contents through the store-data port.

// File: rtl/mcd_pkg.sv
// Shared definitions for the multicycle datapath: ALU operation codes.
package mcd_pkg;
    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;
endpackage

// File: rtl/mcd_alu.sv
// Integer ALU. Computes one of five operations on two operands and flags
// a zero result and signed overflow of add/subtract. Assumes two's complement.
module mcd_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [2:0]   fn,
    output logic [W-1:0] res,
    output logic         zero,
    output logic         ovf
);
    import mcd_pkg::*;

    logic [W-1:0] sum, dif;
    logic         lt;

    assign sum = x + y;
    assign dif = x - y;
    // Signed less-than: operand signs decide when they differ.
    assign lt  = (x[W-1] ^ y[W-1]) ? x[W-1] : dif[W-1];

    // Select the result and overflow per operation code.
    always_comb begin
        res = '0;
        ovf = 1'b0;
        case (alu_fn_e'(fn))
            ALU_ADD: begin
                res = sum;
                ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
            end
            ALU_SUB: begin
                res = dif;
                ovf = (x[W-1] != y[W-1]) && (dif[W-1] != x[W-1]);
            end
            ALU_AND: res = x & y;
            ALU_OR:  res = x | y;
            ALU_SLT: res = {{(W-1){1'b0}}, lt};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);
endmodule

// File: rtl/mcd_regfile.sv
// Register file, two combinational read ports, one write port.
// Entry 0 is hard-wired to zero. Assumes DEPTH is a power of two.
module mcd_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            // Write this entry when addressed.
            always_ff @(posedge clk) begin
                if (we && wa == AW'(g)) regs[g] <= wd;
            end
        end
    end

    assign rd_a = regs[ra];
    assign rd_b = regs[rb];
endmodule

// File: rtl/mcd_opsel.sv
// ALU operand selection: PC or operand latch on X; operand latch,
// constant 4, sign-extended immediate or immediate*4 on Y.
module mcd_opsel #(
    parameter int W = 32
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [15:0]  imm,
    input  logic         opa_sel,
    input  logic [1:0]   opb_sel,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] sx;

    assign sx = {{(W-16){imm[15]}}, imm};
    assign x  = opa_sel ? a : pc;

    // Choose operand Y.
    always_comb begin
        case (opb_sel)
            2'd0:    y = b;
            2'd1:    y = W'(4);
            2'd2:    y = sx;
            default: y = {sx[W-3:0], 2'b00};
        endcase
    end
endmodule

// File: rtl/mc_datapath.sv
// Multicycle datapath top. Holds PC, instruction, memory data, operand and
// ALU result registers; all selects and enables come from an outside
// sequencer. Assumes a combinational-read memory outside the block.
module mc_datapath #(
    parameter int DATA_W   = 32,
    parameter int RF_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              ir_wr,
    input  logic              reg_wr,
    input  logic              dst_sel,
    input  logic              wb_sel,
    input  logic              opa_sel,
    input  logic [1:0]        opb_sel,
    input  logic [2:0]        alu_fn,
    input  logic [1:0]        pc_src,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] instr,
    output logic              zero,
    output logic              ovf
);
    localparam int RA_W = $clog2(RF_DEPTH);

    logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [DATA_W-1:0] pc_nxt, jmp_tgt, alu_x, alu_y_in, alu_y;
    logic [DATA_W-1:0] rf_rd_a, rf_rd_b, wb_data;
    logic [RA_W-1:0]   wb_addr;
    logic              pc_en;

    mcd_opsel #(.W(DATA_W)) u_opsel (
        .pc(pc_q), .a(a_q), .b(b_q), .imm(ir_q[15:0]),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .x(alu_x), .y(alu_y_in)
    );

    mcd_alu #(.W(DATA_W)) u_alu (
        .x(alu_x), .y(alu_y_in), .fn(alu_fn),
        .res(alu_y), .zero(zero), .ovf(ovf)
    );

    assign wb_addr = dst_sel ? ir_q[11 +: RA_W] : ir_q[16 +: RA_W];
    assign wb_data = wb_sel ? mdr_q : aluout_q;

    mcd_regfile #(.W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
        .clk(clk), .ra(ir_q[21 +: RA_W]), .rb(ir_q[16 +: RA_W]),
        .we(reg_wr), .wa(wb_addr), .wd(wb_data),
        .rd_a(rf_rd_a), .rd_b(rf_rd_b)
    );

    assign jmp_tgt = {pc_q[DATA_W-1:28], ir_q[25:0], 2'b00};
    assign pc_en   = pc_wr | (pc_wr_cond & zero);

    // Pick the next PC value.
    always_comb begin
        case (pc_src)
            2'd0:    pc_nxt = alu_y;
            2'd1:    pc_nxt = aluout_q;
            2'd2:    pc_nxt = jmp_tgt;
            default: pc_nxt = pc_q;
        endcase
    end

    // Update PC and instruction register, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_en) pc_q <= pc_nxt;
            if (ir_wr) ir_q <= mem_rdata;
        end
    end

    // Capture the per-cycle holding registers with no enable.
    always_ff @(posedge clk) begin
        mdr_q    <= mem_rdata;
        a_q      <= rf_rd_a;
        b_q      <= rf_rd_b;
        aluout_q <= alu_y;
    end

    assign mem_addr  = addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign instr     = ir_q;
endmodule

// File: rtl/mcd_chk.sv
// Protocol checker for mc_datapath, bound into every instance.
module mcd_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pc_wr,
    input logic         pc_wr_cond,
    input logic [1:0]   pc_src,
    input logic         ir_wr,
    input logic         zero,
    input logic         ovf,
    input logic [2:0]   alu_fn,
    input logic [W-1:0] instr,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] alu_y,
    input logic [W-1:0] a_q,
    input logic [W-1:0] rf_rd_b,
    input logic [W-1:0] mem_wdata
);
    // R1
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> pc_q == '0);

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    // R10
    pc_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'd0) |=> pc_q == $past(alu_y));

    // R6
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(instr));

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |=> a_q == '0);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (alu_fn == 3'd0 || alu_fn == 3'd1));

    // R11
    b_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mem_wdata == $past(rf_rd_b));
endmodule

bind mc_datapath mcd_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .pc_src(pc_src), .ir_wr(ir_wr), .zero(zero), .ovf(ovf),
    .alu_fn(alu_fn), .instr(instr), .pc_q(pc_q), .alu_y(alu_y),
    .a_q(a_q), .rf_rd_b(rf_rd_b), .mem_wdata(mem_wdata)
);

// File: tb/sim_mc_datapath.sv
module sim_mc_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, opa_sel;
    logic [1:0]  opb_sel, pc_src;
    logic [2:0]  alu_fn;
    logic        pc_wr, pc_wr_cond, mem_we;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, instr;
    logic        zero, ovf;
    logic [31:0] mem [256];
    logic [31:0] exp_pc;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    mc_datapath u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .ir_wr(ir_wr),
        .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .alu_fn(alu_fn),
        .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .instr(instr), .zero(zero), .ovf(ovf)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    typedef struct packed {
        logic [4:0]  rs, rt, rd;
        logic [2:0]  fn;
        logic [31:0] res;
        logic        ov;
        logic [31:0] rdv;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{5'd1, 5'd2, 5'd7, 3'd0, 32'd12,         1'b0, 32'd12},
        '{5'd1, 5'd2, 5'd7, 3'd1, 32'd2,          1'b0, 32'd2},
        '{5'd1, 5'd2, 5'd7, 3'd2, 32'd5,          1'b0, 32'd5},
        '{5'd1, 5'd2, 5'd7, 3'd3, 32'd7,          1'b0, 32'd7},
        '{5'd2, 5'd1, 5'd7, 3'd4, 32'd1,          1'b0, 32'd1},
        '{5'd1, 5'd2, 5'd7, 3'd4, 32'd0,          1'b0, 32'd0},
        '{5'd6, 5'd4, 5'd7, 3'd4, 32'd1,          1'b0, 32'd1},
        '{5'd5, 5'd3, 5'd7, 3'd4, 32'd1,          1'b0, 32'd1},
        '{5'd3, 5'd4, 5'd7, 3'd0, 32'h8000_0000,  1'b1, 32'h8000_0000},
        '{5'd5, 5'd4, 5'd7, 3'd1, 32'h7FFF_FFFF,  1'b1, 32'h7FFF_FFFF},
        '{5'd6, 5'd4, 5'd7, 3'd0, 32'd0,          1'b0, 32'd0},
        '{5'd0, 5'd1, 5'd0, 3'd0, 32'd7,          1'b0, 32'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ctl_idle();
        addr_sel = 0; ir_wr = 0; reg_wr = 0; dst_sel = 0; wb_sel = 0;
        opa_sel = 0; opb_sel = 0; alu_fn = 0; pc_src = 0; pc_wr = 0;
        pc_wr_cond = 0; mem_we = 0;
    endtask

    // Fetch: IR <= mem[PC], PC <= PC + 4 (R2 address, R3 constant 4, R10 live result)
    task automatic fetch(input logic [31:0] ins);
        mem[exp_pc[9:2]] = ins;
        ctl_idle();
        ir_wr = 1; opb_sel = 2'd1; pc_wr = 1;
        #1 chk("R2/R10 fetch address", mem_addr, exp_pc);
        @(negedge clk);
        exp_pc += 4;
        chk("R6 instruction loaded", instr, ins);
    endtask

    // Decode: ALU result register <= PC + (imm << 2) (R3)
    task automatic decode();
        ctl_idle();
        opb_sel = 2'd3;
        @(negedge clk);
    endtask

    task automatic load(input logic [4:0] rt, input logic [15:0] off);
        fetch({6'h23, 5'd0, rt, off});
        decode();
        ctl_idle(); opa_sel = 1; opb_sel = 2'd2;
        @(negedge clk);
        ctl_idle(); addr_sel = 1;
        #1 chk("R2 data address", mem_addr, {16'd0, off});
        @(negedge clk);
        ctl_idle(); reg_wr = 1; dst_sel = 0; wb_sel = 1;
        @(negedge clk);
    endtask

    // Observe register r through the store-data port (R11)
    task automatic probe(input logic [4:0] r, input logic [31:0] expv, input string tag);
        fetch({6'h2b, 5'd0, r, 16'h0});
        decode();
        chk(tag, mem_wdata, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[64] = 32'd7;         mem[65] = 32'd5;
        mem[66] = 32'h7FFF_FFFF; mem[67] = 32'd1;
        mem[68] = 32'h8000_0000; mem[69] = 32'hFFFF_FFFF;
        mem[0]  = 32'hDEAD_BEEF;
        ctl_idle();
        exp_pc = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset PC", mem_addr, 32'd0);
        chk("R1 reset IR", instr, 32'd0);
        rst_n = 1;

        // R7 (dst from instr[20:16], data from MDR)
        load(5'd1, 16'h0100); load(5'd2, 16'h0104); load(5'd3, 16'h0108);
        load(5'd4, 16'h010C); load(5'd5, 16'h0110); load(5'd6, 16'h0114);
        probe(5'd1, 32'd7, "R7 load r1");
        probe(5'd6, 32'hFFFF_FFFF, "R7 load r6");

        // Vector table: register operations R4, R5, R7, R8
        foreach (VEC[i]) begin
            fetch({6'h00, VEC[i].rs, VEC[i].rt, VEC[i].rd, 5'd0, 6'h20});
            decode();
            ctl_idle(); opa_sel = 1; opb_sel = 2'd0; alu_fn = VEC[i].fn;
            #1 chk("R5 overflow flag", {31'd0, ovf}, {31'd0, VEC[i].ov});
            @(negedge clk);
            ctl_idle(); reg_wr = 1; dst_sel = 1; wb_sel = 0; addr_sel = 1;
            #1 chk("R4 ALU result", mem_addr, VEC[i].res);
            @(negedge clk);
            probe(VEC[i].rd, VEC[i].rdv, "R8/R7 destination value");
        end

        // Store r1 to 0x120 (R11 write data, R2)
        fetch({6'h2b, 5'd0, 5'd1, 16'h0120});
        decode();
        ctl_idle(); opa_sel = 1; opb_sel = 2'd2;
        @(negedge clk);
        ctl_idle(); addr_sel = 1; mem_we = 1;
        #1 chk("R2 store address", mem_addr, 32'h120);
        @(negedge clk);
        ctl_idle();
        chk("R11 stored word", mem[72], 32'd7);

        // Hold cycle: IR and PC unchanged without enables (R6, R9)
        begin
            logic [31:0] held;
            held = instr;
            mem[exp_pc[9:2]] = 32'h1234_5678;
            @(negedge clk);
            chk("R6 IR hold", instr, held);
            chk("R9 PC hold", mem_addr, exp_pc);
        end

        // Taken branch r1 == r1, offset 3 (R9, R3, R10 source 1)
        fetch({6'h04, 5'd1, 5'd1, 16'd3});
        decode();
        ctl_idle(); opa_sel = 1; alu_fn = 3'd1; pc_src = 2'd1; pc_wr_cond = 1;
        #1 chk("R9 zero on equal", {31'd0, zero}, 32'd1);
        @(negedge clk);
        exp_pc = exp_pc + 32'd12;

        // Untaken branch r1 != r2
        fetch({6'h04, 5'd1, 5'd2, 16'd3});
        decode();
        ctl_idle(); opa_sel = 1; alu_fn = 3'd1; pc_src = 2'd1; pc_wr_cond = 1;
        @(negedge clk);

        // Jump to word index 0x80 (R10 source 2)
        fetch({6'h02, 26'h80});
        decode();
        ctl_idle(); pc_src = 2'd2; pc_wr = 1;
        @(negedge clk);
        exp_pc = 32'h200;
        probe(5'd2, 32'd5, "R10 after jump r2");

        // Mid-run reset (R1)
        ctl_idle(); rst_n = 0;
        @(negedge clk);
        chk("R1 reset mid-run PC", mem_addr, 32'd0);
        chk("R1 reset mid-run IR", instr, 32'd0);
        rst_n = 1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule